// File: doc/BRIEF.md
# Watchdog Timer with Keyed Run Control

This block is a watchdog timer with a small register-mapped bus port. A free-running up-counter advances once per clock. When it passes its all-ones value, it reloads from a programmable reload register and asserts a one-cycle reset-request output. The counter is already running when hard reset is released, and again after a soft reset, so a system whose software never touches the block is still protected.

The timer can only be halted or resumed through one control register, and each change needs an ordered pair of magic words. A write to that register is posted. It is held in a fixed-latency stage that stands in for a clock-domain crossing, and it takes effect only when that stage drains. While the stage is busy, a status flag reads high and further key writes are dropped. Software therefore polls the flag between the two words of a pair.

A soft-reset bit returns every register to its reset value. The bit clears itself, and a completion flag reports when the reset has finished.

Top module: `wdog_keyed_top`

## Requirements
- R1: After hard reset the timer runs with count 0 and reload 0, incrementing by one per cycle. STAT (0x14) reads 0x3: bit 0 is reset-done and bit 1 is running. Bit 4 of the posting register at 0x34 reads 0.
- R2: Writing 0xAAAA and then 0x5555 to the key register at 0x48 stops the timer, and STAT bit 1 then reads 0.
- R3: Writing 0xBBBB and then 0x4444 to the key register starts a stopped timer, and STAT bit 1 then reads 1.
- R4: If the second word of a pair is not the follow-on of the first (for example 0xBBBB then 0x1234, or 0xAAAA then 0x4444), the pair is discarded and the run state is unchanged.
- R5: An accepted key write sets bit 4 of 0x34 for exactly 4 cycles, starting at the edge that samples the write. The key acts on the run state at the edge where the bit clears.
- R6: A key write made while bit 4 of 0x34 is set is ignored. Reading 0x48 keeps returning the last accepted key word.
- R7: When the running counter steps past 0xFFFFFFFF, it loads the reload value and drives the reset-request output high for one cycle, at the same edge.
- R8: While the timer is stopped, the count holds and the reset-request output stays low.
- R9: Writing 1 to bit 1 of CTRL (0x10) restores every register to its reset value, which includes setting the timer running. The bit reads 1 for one cycle and then clears itself.
- R10: STAT bit 0 reads 0 from the soft-reset request until two edges later, and then reads 1.
- R11: The count at 0x28 and the reload value at 0x2C can be written directly and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational decode of bus_addr |
| wdog_rst_req | output | 1 | One-cycle reset request on counter wrap |

## Verification
A corrupted key-sequence state shows as a run bit that fails to change four edges after the second key word, or that changes after a mismatched word. Either case is seen on the next STAT read. A posting counter of the wrong length shows up as soon as bit 4 of 0x34 drops one cycle early or late, and it also shifts when the run state changes. Counter faults appear as a reset request in the wrong cycle, as a missing request, or as a wrong reload value read back on the cycle of the wrap. Soft-reset faults appear within two cycles as a wrong reset-done or self-clearing bit.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int unsigned BUS_AW = 8;
    localparam int unsigned BUS_DW = 32;
    localparam int unsigned KEY_W  = 16;

    localparam logic [BUS_AW-1:0] ADDR_CTRL  = 8'h10;
    localparam logic [BUS_AW-1:0] ADDR_STAT  = 8'h14;
    localparam logic [BUS_AW-1:0] ADDR_COUNT = 8'h28;
    localparam logic [BUS_AW-1:0] ADDR_LOAD  = 8'h2C;
    localparam logic [BUS_AW-1:0] ADDR_POST  = 8'h34;
    localparam logic [BUS_AW-1:0] ADDR_KEY   = 8'h48;

    localparam int unsigned CTRL_SRST_BIT = 1;
    localparam int unsigned STAT_DONE_BIT = 0;
    localparam int unsigned STAT_RUN_BIT  = 1;
    localparam int unsigned POST_PEND_BIT = 4;

    localparam logic [KEY_W-1:0] KEY_HALT_1 = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_HALT_2 = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_GO_1   = 16'hBBBB;
    localparam logic [KEY_W-1:0] KEY_GO_2   = 16'h4444;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_HALT_A = 2'd1,
        SEQ_GO_A   = 2'd2
    } seq_e;
endpackage

// File: rtl/wdog_post.sv
module wdog_post #(
    parameter int unsigned LAT = 4,
    parameter int unsigned KW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [KW-1:0] wr_key,
    output logic          pending,
    output logic          apply,
    output logic [KW-1:0] key
);
    localparam int unsigned CW = $clog2(LAT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [KW-1:0] key;
    } post_st_t;

    post_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else if (wr_en) begin
            st_d.cnt = CW'(LAT);
            st_d.key = wr_key;
        end
        if (clr) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = (st_q.cnt != '0);
    assign apply   = (st_q.cnt == CW'(1));
    assign key     = st_q.key;
endmodule

// File: rtl/wdog_keyseq.sv
module wdog_keyseq
    import wdog_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             apply,
    input  logic [KEY_W-1:0] key,
    output logic             running
);
    typedef struct packed {
        logic run;
        seq_e seq;
    } ks_st_t;

    localparam ks_st_t KS_RST = '{run: 1'b1, seq: SEQ_IDLE};

    ks_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (apply) begin
            if (key == KEY_HALT_1) begin
                st_d.seq = SEQ_HALT_A;
            end else if (key == KEY_GO_1) begin
                st_d.seq = SEQ_GO_A;
            end else begin
                if (st_q.seq == SEQ_HALT_A && key == KEY_HALT_2) begin
                    st_d.run = 1'b0;
                end
                if (st_q.seq == SEQ_GO_A && key == KEY_GO_2) begin
                    st_d.run = 1'b1;
                end
                st_d.seq = SEQ_IDLE;
            end
        end
        if (clr) begin
            st_d = KS_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= KS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign running = st_q.run;
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
    parameter int unsigned W        = 32,
    parameter logic [W-1:0] CNT_RST  = '0,
    parameter logic [W-1:0] LOAD_RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic         cnt_we,
    input  logic         load_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt,
    output logic [W-1:0] load,
    output logic         req
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] load;
        logic         req;
    } cnt_st_t;

    localparam cnt_st_t CNT_ST_RST = '{cnt: CNT_RST, load: LOAD_RST, req: 1'b0};

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        if (run) begin
            if (st_q.cnt == {W{1'b1}}) begin
                st_d.cnt = st_q.load;
                st_d.req = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (load_we) begin
            st_d.load = wdata;
        end
        if (cnt_we) begin
            st_d.cnt = wdata;
            st_d.req = 1'b0;
        end
        if (clr) begin
            st_d = CNT_ST_RST;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CNT_ST_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign load = st_q.load;
    assign req  = st_q.req;
endmodule

// File: rtl/wdog_keyed_top.sv
module wdog_keyed_top
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned SYNC_LAT      = 4,
    parameter int unsigned SRST_DONE_LAT = 2,
    parameter logic [CNT_W-1:0] CNT_RST  = '0,
    parameter logic [CNT_W-1:0] LOAD_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              wdog_rst_req
);
    localparam int unsigned PH_W = $clog2(SRST_DONE_LAT + 1);

    typedef struct packed {
        logic [PH_W-1:0] ph;
        logic            done;
    } top_st_t;

    localparam top_st_t TOP_RST = '{ph: '0, done: 1'b1};

    top_st_t st_d, st_q;

    logic             wr_any;
    logic             srst_req;
    logic             key_we;
    logic             cnt_we;
    logic             load_we;
    logic             pend_w;
    logic             apply_w;
    logic [KEY_W-1:0] key_w;
    logic             run_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] load_w;
    logic             done_w;

    assign wr_any   = bus_sel && bus_wr;
    assign srst_req = wr_any && (bus_addr == ADDR_CTRL) && bus_wdata[CTRL_SRST_BIT];
    assign key_we   = wr_any && (bus_addr == ADDR_KEY) && !srst_req;
    assign cnt_we   = wr_any && (bus_addr == ADDR_COUNT);
    assign load_we  = wr_any && (bus_addr == ADDR_LOAD);

    always_comb begin
        st_d = st_q;
        if (srst_req) begin
            st_d.ph   = PH_W'(SRST_DONE_LAT);
            st_d.done = 1'b0;
        end else if (st_q.ph != '0) begin
            st_d.ph = st_q.ph - 1'b1;
            if (st_q.ph == PH_W'(1)) begin
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TOP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_w = st_q.done;

    wdog_post #(
        .LAT (SYNC_LAT),
        .KW  (KEY_W)
    ) u_post (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst_req),
        .wr_en   (key_we),
        .wr_key  (bus_wdata[KEY_W-1:0]),
        .pending (pend_w),
        .apply   (apply_w),
        .key     (key_w)
    );

    wdog_keyseq u_keyseq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst_req),
        .apply   (apply_w),
        .key     (key_w),
        .running (run_w)
    );

    wdog_count #(
        .W        (CNT_W),
        .CNT_RST  (CNT_RST),
        .LOAD_RST (LOAD_RST)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst_req),
        .run     (run_w),
        .cnt_we  (cnt_we),
        .load_we (load_we),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .cnt     (cnt_w),
        .load    (load_w),
        .req     (wdog_rst_req)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL:  bus_rdata[CTRL_SRST_BIT] = (st_q.ph == PH_W'(SRST_DONE_LAT));
            ADDR_STAT: begin
                bus_rdata[STAT_DONE_BIT] = st_q.done;
                bus_rdata[STAT_RUN_BIT]  = run_w;
            end
            ADDR_COUNT: bus_rdata[CNT_W-1:0] = cnt_w;
            ADDR_LOAD:  bus_rdata[CNT_W-1:0] = load_w;
            ADDR_POST:  bus_rdata[POST_PEND_BIT] = pend_w;
            ADDR_KEY:   bus_rdata[KEY_W-1:0] = key_w;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_keyed_chk.sv
module wdog_keyed_chk #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned SYNC_LAT = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             pending,
    input logic             apply,
    input logic             srst_req,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] load,
    input logic             rst_req,
    input logic             done
);
    localparam int unsigned LW = $clog2(SYNC_LAT + 2);

    logic [LW-1:0] hi_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len <= '0;
        end else if (pending) begin
            hi_len <= hi_len + 1'b1;
        end else begin
            hi_len <= '0;
        end
    end

    assert_pend_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (hi_len < LW'(SYNC_LAT)));

    assert_pend_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pending) && !$past(srst_req)) |-> (hi_len == LW'(SYNC_LAT)));

    assert_run_on_apply_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!apply && !srst_req) |=> $stable(run));

    assert_wrap_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ($past(run) && ($past(cnt) == {CNT_W{1'b1}})));

    assert_wrap_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> (cnt == $past(load)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_we && !srst_req) |=> $stable(cnt));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !rst_req);

    assert_rearm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> run);

    assert_done_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_req |=> !done);
endmodule

bind wdog_keyed_top wdog_keyed_chk #(
    .CNT_W    (CNT_W),
    .SYNC_LAT (SYNC_LAT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .pending  (pend_w),
    .apply    (apply_w),
    .srst_req (srst_req),
    .cnt_we   (cnt_we),
    .cnt      (cnt_w),
    .load     (load_w),
    .rst_req  (wdog_rst_req),
    .done     (done_w)
);

// File: tb/sim_wdog_keyed_top.sv
module sim_wdog_keyed_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_rst_req;

    int n_chk = 0;
    int n_err = 0;
    bit done_all = 1'b0;

    always #10 clk = ~clk;

    wdog_keyed_top u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .wdog_rst_req (wdog_rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic wait_clear();
        logic [31:0] v;
        for (int i = 0; i < 20; i++) begin
            bus_read(8'h34, v);
            if (v[4] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic key_pair(input logic [15:0] k1, input logic [15:0] k2);
        bus_write(8'h48, {16'h0, k1});
        wait_clear();
        bus_write(8'h48, {16'h0, k2});
        wait_clear();
    endtask

    task automatic t_reset();
        logic [31:0] v, c0, c1;
        bus_read(8'h14, v);  check("R1 stat", v, 32'h3);
        bus_read(8'h34, v);  check("R1 post", v, 32'h0);
        bus_read(8'h2C, v);  check("R1 load", v, 32'h0);
        bus_read(8'h28, c0);
        @(negedge clk);
        bus_read(8'h28, c1);
        check("R1 count step", c1 - c0, 32'h1);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        bus_write(8'h48, 32'hAAAA);
        bus_read(8'h34, v); check("R5 pend c0", v, 32'h10);
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            bus_read(8'h34, v); check("R5 pend mid", v, 32'h10);
        end
        @(negedge clk);
        bus_read(8'h34, v); check("R5 pend clear", v, 32'h0);
        bus_write(8'h48, 32'h5555);
        for (int i = 1; i < 4; i++) @(negedge clk);
        bus_read(8'h14, v); check("R5 not yet", v[1], 1'b1);
        @(negedge clk);
        bus_read(8'h14, v); check("R2 stopped", v[1], 1'b0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        int hits = 0;
        bus_write(8'h28, 32'hFFFF_FFFE);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wdog_rst_req) hits++;
        end
        check("R8 no request", hits, 0);
        bus_read(8'h28, v); check("R8 count held", v, 32'hFFFF_FFFE);
    endtask

    task automatic t_mismatch();
        logic [31:0] v;
        key_pair(16'hBBBB, 16'h1234);
        bus_read(8'h14, v); check("R4 stays stopped", v[1], 1'b0);
    endtask

    task automatic t_ignore_start();
        logic [31:0] v;
        bus_write(8'h48, 32'hBBBB);
        bus_write(8'h48, 32'h4444);
        wait_clear();
        bus_read(8'h14, v); check("R6 still stopped", v[1], 1'b0);
        bus_read(8'h48, v); check("R6 key kept", v, 32'hBBBB);
        bus_write(8'h48, 32'h4444);
        wait_clear();
        bus_read(8'h14, v); check("R3 running", v[1], 1'b1);
    endtask

    task automatic t_mismatch_run();
        logic [31:0] v;
        key_pair(16'hAAAA, 16'h4444);
        bus_read(8'h14, v); check("R4 stays running", v[1], 1'b1);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        int hits = 0;
        int at = -1;
        bus_write(8'h2C, 32'h0000_1000);
        bus_read(8'h2C, v); check("R11 load rb", v, 32'h0000_1000);
        bus_write(8'h28, 32'hFFFF_FFFA);
        bus_read(8'h28, v); check("R11 count rb", v, 32'hFFFF_FFFA);
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (wdog_rst_req) begin
                hits++;
                at = i;
                bus_read(8'h28, v); check("R7 reload", v, 32'h0000_1000);
            end
        end
        check("R7 single pulse", hits, 1);
        check("R7 pulse cycle", at, 6);
        bus_read(8'h28, v); check("R7 after", v, 32'h0000_1006);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v, c0, c1;
        key_pair(16'hAAAA, 16'h5555);
        bus_write(8'h2C, 32'h55);
        bus_write(8'h10, 32'h2);
        bus_read(8'h10, v); check("R9 bit set", v, 32'h2);
        bus_read(8'h14, v); check("R10 done low, R9 run", v, 32'h2);
        bus_read(8'h2C, v); check("R9 load reset", v, 32'h0);
        @(negedge clk);
        bus_read(8'h10, v); check("R9 self clear", v, 32'h0);
        bus_read(8'h14, v); check("R10 done low 2", v[0], 1'b0);
        @(negedge clk);
        bus_read(8'h14, v); check("R10 done set", v, 32'h3);
        bus_read(8'h28, c0);
        @(negedge clk);
        bus_read(8'h28, c1);
        check("R9 counting", c1 - c0, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stop();
        t_hold();
        t_mismatch();
        t_ignore_start();
        t_mismatch_run();
        t_wrap();
        t_soft_reset();
        done_all = 1'b1;
    end

    initial begin
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (done_all) break;
        end
        if (!done_all) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule